// File: doc/BRIEF.md
# LCD display timing generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal and vertical sync, a data-enable window, a pixel-strobe output, the current pixel position, and single-cycle start-of-frame and end-of-frame strobes for the fetch and interrupt logic that sit beside it. It advances one pixel on every clock on which the pixel-enable input is high, so the pixel rate is set by whoever drives that input.

Software programs the two sync widths, one packed register of totals, and two packed display-area registers through a simple register port. All positions are absolute counts from the start of sync. For example, a display start of 3 means a sync width plus a back porch of 3 pixels. A start request sets the raster running from position (0,0). A stop request is held pending until the last pixel of the current frame, so the panel never receives a partial frame. At that point a sticky stopped flag is raised, and software clears it by writing zero. A polarity register inverts any of the four panel outputs, and it also sets their level while the block is idle.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the block is stopped. hpos_o and vpos_o read 0, and hsync_o, vsync_o, de_o, pclk_o, sof_o, eof_o and stopped_o are all 0. Every register reads 0.
- R2: The register port has the following map. Address 3 holds the horizontal sync width and address 4 the vertical sync width, each as a 10-bit value (bits 9:0), with the upper bits dropped. Address 5 holds the horizontal total in bits 31:16 and the vertical total in bits 15:0. Address 6 holds the horizontal start in bits 31:16 and the horizontal end in bits 15:0. Address 7 holds the vertical start and end in the same layout. Address 2 holds polarity bits 11:8. Each register reads back what was stored, and a write takes effect on the next clock.
- R3: While running, on each clock with pix_ce high, hpos advances by one. After the pixel at position horizontal total minus 1, hpos returns to 0 and vpos advances, wrapping in the same way at the vertical total. A total of 0 behaves as 1. With pix_ce low, the position holds.
- R4: While running, the active level of hsync is present exactly while hpos is below the horizontal sync width. The active level of vsync is present exactly while vpos is below the vertical sync width.
- R5: While running, the active level of de is present exactly while hpos is in [horizontal start, horizontal end) and vpos is in [vertical start, vertical end).
- R6: Polarity bit 8 inverts vsync_o, bit 9 inverts de_o, bit 10 inverts pclk_o and bit 11 inverts hsync_o. When stopped, each of these outputs sits at the level of its polarity bit.
- R7: pclk_o shows its active level in the clock cycle after every cycle in which the block is running with pix_ce high.
- R8: Writing the control register (address 0) with bit 3 set and bit 4 clear while stopped starts the raster at (0,0) on the next clock. The same write while running has no effect. Control read bit 3 shows running.
- R9: Writing control bit 4 while running makes a stop pending, and control read bit 4 shows it. The block keeps running until the clock that ends the frame: pix_ce high at hpos = horizontal total minus 1 and vpos = vertical total minus 1. It then stops with the position at 0 and sets the stopped flag.
- R10: The stopped flag is status bit 0 (address 1) and also drives stopped_o. It stays set until a status write with bit 0 = 0 clears it.
- R11: sof_o is high in a running cycle with pix_ce high at position (0,0). eof_o is high in the frame-ending cycle defined in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel strobe |
| sof_o | output | 1 | Start-of-frame strobe |
| eof_o | output | 1 | End-of-frame strobe |
| hpos_o | output | 16 | Horizontal position |
| vpos_o | output | 16 | Vertical position |
| stopped_o | output | 1 | Stopped flag |

## Verification
The hardest situation to reach is a pending stop that meets a frame end while pix_ce is gapped. The stop must wait for a clock that has pix_ce high at the last position, and not merely for the position to be reached. The stimulus therefore issues stop requests mid-frame under a repeating pix_ce pattern that includes idle cycles. It also uses a geometry where both totals are 0, so that every pixel is a frame end. Degenerate windows are covered as well: a zero sync width, and a vertical end beyond the total. A behavioural model compares every output and every readback register on each clock throughout all of these cases.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 16,
  parameter int SW = 10,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_ce,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*CW-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*CW-1:0] rd_data,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic            pclk_o,
  output logic            sof_o,
  output logic            eof_o,
  output logic [CW-1:0]   hpos_o,
  output logic [CW-1:0]   vpos_o,
  output logic            stopped_o
);
  localparam int DW = 2 * CW;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_POL  = AW'(2);
  localparam logic [AW-1:0] A_HSW  = AW'(3);
  localparam logic [AW-1:0] A_VSW  = AW'(4);
  localparam logic [AW-1:0] A_TOT  = AW'(5);
  localparam logic [AW-1:0] A_HWIN = AW'(6);
  localparam logic [AW-1:0] A_VWIN = AW'(7);
  localparam int B_RUN  = 3;
  localparam int B_STOP = 4;
  localparam int B_POL  = 8;

  logic [SW-1:0] hsw, vsw;
  logic [CW-1:0] htot, vtot, hbeg, hend, vbeg, vend;
  logic [3:0]    pol;
  logic [CW-1:0] hcnt, vcnt;
  logic          running, dis_req, stopped, pclk_r;

  wire step      = running & pix_ce;
  wire h_last    = ({1'b0, hcnt} + 1'b1) >= {1'b0, htot};
  wire v_last    = ({1'b0, vcnt} + 1'b1) >= {1'b0, vtot};
  wire frame_end = step & h_last & v_last;
  wire ctrl_wr   = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsw <= '0; vsw <= '0; htot <= '0; vtot <= '0;
      hbeg <= '0; hend <= '0; vbeg <= '0; vend <= '0;
      pol <= '0; hcnt <= '0; vcnt <= '0;
      running <= 1'b0; dis_req <= 1'b0; stopped <= 1'b0; pclk_r <= 1'b0;
    end else begin
      pclk_r <= step;
      if (wr_en) begin
        case (wr_addr)
          A_POL:  pol <= wr_data[B_POL +: 4];
          A_HSW:  hsw <= wr_data[SW-1:0];
          A_VSW:  vsw <= wr_data[SW-1:0];
          A_TOT:  {htot, vtot} <= wr_data;
          A_HWIN: {hbeg, hend} <= wr_data;
          A_VWIN: {vbeg, vend} <= wr_data;
          A_STAT: stopped <= stopped & wr_data[0];
          default: ;
        endcase
      end
      if (running) begin
        if (ctrl_wr && wr_data[B_STOP]) dis_req <= 1'b1;
        if (step) begin
          hcnt <= h_last ? '0 : hcnt + 1'b1;
          if (h_last) vcnt <= v_last ? '0 : vcnt + 1'b1;
        end
        if (frame_end && dis_req) begin
          running <= 1'b0;
          dis_req <= 1'b0;
          stopped <= 1'b1;
          hcnt    <= '0;
          vcnt    <= '0;
        end
      end else if (ctrl_wr && wr_data[B_RUN] && !wr_data[B_STOP]) begin
        running <= 1'b1;
        hcnt    <= '0;
        vcnt    <= '0;
      end
    end
  end

  wire hs_act = running && (hcnt < CW'(hsw));
  wire vs_act = running && (vcnt < CW'(vsw));
  wire de_act = running && (hcnt >= hbeg) && (hcnt < hend) &&
                (vcnt >= vbeg) && (vcnt < vend);

  assign vsync_o   = vs_act ^ pol[0];
  assign de_o      = de_act ^ pol[1];
  assign pclk_o    = pclk_r ^ pol[2];
  assign hsync_o   = hs_act ^ pol[3];
  assign sof_o     = step && (hcnt == '0) && (vcnt == '0);
  assign eof_o     = frame_end;
  assign hpos_o    = hcnt;
  assign vpos_o    = vcnt;
  assign stopped_o = stopped;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_RUN]  = running;
        rd_data[B_STOP] = dis_req;
      end
      A_STAT: rd_data[0] = stopped;
      A_POL:  rd_data[B_POL +: 4] = pol;
      A_HSW:  rd_data[SW-1:0] = hsw;
      A_VSW:  rd_data[SW-1:0] = vsw;
      A_TOT:  rd_data = {htot, vtot};
      A_HWIN: rd_data = {hbeg, hend};
      A_VWIN: rd_data = {vbeg, vend};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_bit0,
  input logic          running,
  input logic          dis_req,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] htot,
  input logic          eof_o,
  input logic          stopped_o
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_ce) |=> ($stable(hcnt) && $stable(vcnt)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pix_ce && (({1'b0, hcnt} + 1'b1) < {1'b0, htot}))
      |=> (hcnt == $past(hcnt) + 1'b1) && $stable(vcnt));

  assert_start_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (hcnt == '0) && (vcnt == '0));

  assert_run_until_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !eof_o) |=> running);

  assert_stop_at_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dis_req && eof_o) |=> (!running && stopped_o && hcnt == '0 && vcnt == '0));

  assert_stopped_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && !(wr_en && wr_addr == AW'(1) && !wr_bit0)) |=> stopped_o);
endmodule

bind lcd_timing_gen lcd_timing_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .running(running),
  .dis_req(dis_req), .hcnt(hcnt), .vcnt(vcnt), .htot(htot),
  .eof_o(eof_o), .stopped_o(stopped_o)
);

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync_o, vsync_o, de_o, pclk_o, sof_o, eof_o, stopped_o;
  logic [15:0] hpos_o, vpos_o;

  always #2 clk = ~clk;

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o),
    .sof_o(sof_o), .eof_o(eof_o), .hpos_o(hpos_o), .vpos_o(vpos_o),
    .stopped_o(stopped_o)
  );

  int checks = 0, errors = 0;
  int rr = 0;
  bit done = 0;

  // behavioural reference state
  int m_run = 0, m_pend = 0, m_stop = 0, m_h = 0, m_v = 0, m_pstrobe = 0;
  int m_hsw = 0, m_vsw = 0, m_ht = 0, m_vt = 0;
  int m_hb = 0, m_he = 0, m_vb = 0, m_ve = 0, m_pol = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pend = 0; m_stop = 0; m_h = 0; m_v = 0; m_pstrobe = 0;
      m_hsw = 0; m_vsw = 0; m_ht = 0; m_vt = 0;
      m_hb = 0; m_he = 0; m_vb = 0; m_ve = 0; m_pol = 0;
    end else begin
      int adv, endf, was_pend;
      adv  = m_run && pix_ce;
      endf = adv && (m_h + 1 >= m_ht) && (m_v + 1 >= m_vt);
      was_pend = m_pend;
      m_pstrobe = adv;
      if (wr_en) begin
        case (wr_addr)
          3'd1: if (wr_data[0] == 1'b0) m_stop = 0;
          3'd2: m_pol = (wr_data >> 8) & 'hF;
          3'd3: m_hsw = wr_data & 'h3FF;
          3'd4: m_vsw = wr_data & 'h3FF;
          3'd5: begin m_ht = wr_data >> 16; m_vt = wr_data & 'hFFFF; end
          3'd6: begin m_hb = wr_data >> 16; m_he = wr_data & 'hFFFF; end
          3'd7: begin m_vb = wr_data >> 16; m_ve = wr_data & 'hFFFF; end
          default: ;
        endcase
      end
      if (m_run) begin
        if (wr_en && wr_addr == 3'd0 && wr_data[4]) m_pend = 1;
        if (adv) begin
          if (m_h + 1 >= m_ht) begin
            m_h = 0;
            m_v = (m_v + 1 >= m_vt) ? 0 : m_v + 1;
          end else m_h = m_h + 1;
        end
        if (endf && was_pend) begin
          m_run = 0; m_pend = 0; m_stop = 1; m_h = 0; m_v = 0;
        end
      end else if (wr_en && wr_addr == 3'd0 && wr_data[3] && !wr_data[4]) begin
        m_run = 1; m_h = 0; m_v = 0;
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ehs, evs, ede, esof, eeof;
    longint erd;
    ehs  = (m_run && m_h < m_hsw) ^ ((m_pol >> 3) & 1);
    evs  = (m_run && m_v < m_vsw) ^ (m_pol & 1);
    ede  = (m_run && m_h >= m_hb && m_h < m_he && m_v >= m_vb && m_v < m_ve) ^ ((m_pol >> 1) & 1);
    esof = m_run && pix_ce && m_h == 0 && m_v == 0;
    eeof = m_run && pix_ce && (m_h + 1 >= m_ht) && (m_v + 1 >= m_vt);
    chk("R3 hpos", hpos_o, m_h);
    chk("R3 vpos", vpos_o, m_v);
    chk("R4/R6 hsync", hsync_o, ehs);
    chk("R4/R6 vsync", vsync_o, evs);
    chk("R5/R6 de", de_o, ede);
    chk("R7/R6 pclk", pclk_o, m_pstrobe ^ ((m_pol >> 2) & 1));
    chk("R11 sof", sof_o, esof);
    chk("R11 eof", eof_o, eeof);
    chk("R10 stopped_o", stopped_o, m_stop);
    case (rd_addr)
      3'd0: erd = (m_run << 3) | (m_pend << 4);
      3'd1: erd = m_stop;
      3'd2: erd = m_pol << 8;
      3'd3: erd = m_hsw;
      3'd4: erd = m_vsw;
      3'd5: erd = (longint'(m_ht) << 16) | m_vt;
      3'd6: erd = (longint'(m_hb) << 16) | m_he;
      default: erd = (longint'(m_vb) << 16) | m_ve;
    endcase
    chk($sformatf("R2/R8/R9 readback addr %0d", rd_addr), rd_data, erd);
  endtask

  task automatic tick(input bit ce, input bit we, input logic [2:0] wa, input logic [31:0] wd);
    @(negedge clk);
    pix_ce = ce; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr = 3'(rr); rr = (rr + 1) % 8;
    #1 compare_all();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    tick(1'b1, 1'b1, a, d);
  endtask

  task automatic run(input int n, input int gapped);
    for (int i = 0; i < n; i++) tick(gapped ? ((i % 3) != 2) : 1'b1, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic run_until_stop(input int gapped);
    for (int k = 0; k < 400 && !stopped_o; k++)
      tick(gapped ? ((k % 3) != 2) : 1'b1, 1'b0, 3'd0, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3, 0);
    // R1: reset state
    chk("R1 hpos after reset", hpos_o, 0);
    chk("R1 de after reset", de_o, 0);
    chk("R1 stopped after reset", stopped_o, 0);
    rst_n = 1'b1;
    run(2, 0);

    // R2: masking of sync width and packed registers
    wreg(3'd3, 32'hFFFF_FC02);
    wreg(3'd4, 32'd1);
    wreg(3'd5, {16'd10, 16'd6});
    wreg(3'd6, {16'd3, 16'd8});
    wreg(3'd7, {16'd2, 16'd5});
    for (int a = 0; a < 8; a++) tick(1'b0, 1'b0, 3'd0, 32'd0);

    // R8: start, then ignored second start
    wreg(3'd0, 32'h8);
    chk("R8 running next cycle", hpos_o, 0);
    run(200, 0);
    wreg(3'd0, 32'h8);
    run(60, 1);

    // R6: all polarities inverted
    wreg(3'd2, 32'hF00);
    run(100, 1);

    // R9: stop request mid-frame with gapped pix_ce
    wreg(3'd0, 32'h18);
    run_until_stop(1);
    chk("R9 stopped flag raised", stopped_o, 1);
    chk("R9 hpos at origin after stop", hpos_o, 0);
    run(10, 0);
    chk("R6 idle hsync follows polarity", hsync_o, 1);

    // R10: status stays until cleared with 0
    wreg(3'd1, 32'h1);
    chk("R10 write 1 keeps flag", stopped_o, 1);
    wreg(3'd1, 32'h0);
    run(2, 0);
    chk("R10 cleared by 0", stopped_o, 0);

    // second geometry: no hsync, vertical end beyond total
    wreg(3'd2, 32'h0);
    wreg(3'd3, 32'h0);
    wreg(3'd4, 32'd3);
    wreg(3'd5, {16'd7, 16'd5});
    wreg(3'd6, {16'd0, 16'd7});
    wreg(3'd7, {16'd4, 16'd9});
    wreg(3'd0, 32'h8);
    run(120, 1);
    wreg(3'd0, 32'h10);
    run_until_stop(1);
    chk("R9 second stop", stopped_o, 1);
    wreg(3'd1, 32'h0);

    // R3/R11: zero totals, every pixel ends a frame
    wreg(3'd5, 32'h0);
    wreg(3'd0, 32'h8);
    run(12, 1);
    wreg(3'd0, 32'h10);
    run_until_stop(1);
    chk("R11/R9 stop with zero totals", stopped_o, 1);
    run(5, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule